// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Resolver

This unit sits beside a single-precision fused multiply-add datapath. For each strobed operation it looks at the three operands, the two-bit operation select and the rounding direction. It decides whether the final answer can be found without the full-precision multiply and add. Such answers cover NaN inputs, infinities, invalid combinations, and results that are exactly zero or exactly the addend. For these cases the unit supplies the final word and an invalid-operation flag, and it raises a bypass flag. The bypass flag tells the datapath to discard its own result.

The operation select picks one of four forms. Bit 1 negates the product and bit 0 negates the addend, which gives 00 = x*y+z, 01 = x*y-z, 10 = -(x*y)+z and 11 = -(x*y)-z. Both negations are applied to the signs before any special-case evaluation. The external adder can assert a cancellation hint when a finite non-zero product exactly cancels a finite non-zero addend. The unit then supplies the correctly signed zero. All results are registered one cycle behind the input strobe.

Top module: `fma_special_resolver`

## Requirements
- R1: The product sign is sign(x) XOR sign(y) XOR op[1], and the addend sign is sign(z) XOR op[0]. Every signed special result (infinity, zero, passed-through addend) uses these effective signs.
- R2: If any operand is a NaN, the result is derived from the first NaN in the order x, y, z. A quiet NaN (exponent all ones, fraction MSB 1) is returned bit for bit.
- R3: A signalling NaN (exponent all ones, fraction MSB 0, fraction non-zero) is returned with fraction bit 22 forced to 1. If any operand is a signalling NaN, invalid_o is 1, even when the returned NaN comes from a different operand.
- R4: If the effective product and the effective addend are infinities of opposite sign, the result is 0xFFC00000 and invalid_o is 1. Infinities of the same sign give that infinity, with invalid_o 0.
- R5: With no NaN present, zero times infinity (in either order) gives 0xFFC00000 with invalid_o 1, whatever the addend is.
- R6: A zero effective product plus a zero effective addend of the same sign gives that signed zero in all four rounding modes.
- R7: Zeros of opposite effective sign give -0 (0x80000000) when rnd_i = 01 (toward negative). They give +0 under 00 (nearest-even), 10 (toward positive) and 11 (toward zero).
- R8: If cancel_i is high and both the product and the addend are finite non-zero, the result is -0 when rnd_i = 01 and +0 otherwise, with bypass_o 1. cancel_i has no effect in any other operand class.
- R9: A finite non-zero product with a finite non-zero addend (without the hint), or with a zero addend, gives bypass_o 0, result_o 0 and invalid_o 0.
- R10: valid_o is valid_i delayed by one clock. result_o, bypass_o and invalid_o change only in the cycle after a strobe and hold otherwise.
- R11: While rst_ni is low, all outputs are 0.
- R12: A zero product with a finite non-zero addend gives the addend with its effective sign, exactly, with bypass_o 1 and invalid_o 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| x_i | input | 32 | Multiplicand |
| y_i | input | 32 | Multiplier |
| z_i | input | 32 | Addend |
| op_i | input | 2 | Bit 1 negates the product, bit 0 negates the addend |
| rnd_i | input | 2 | 00 nearest-even, 01 toward negative, 10 toward positive, 11 toward zero |
| cancel_i | input | 1 | Exact cancellation hint from the adder |
| valid_o | output | 1 | Strobe delayed by one cycle |
| bypass_o | output | 1 | Special result overrides the datapath |
| result_o | output | 32 | Special-case result word |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
Each result is due on the first rising edge after the strobe, because a single register stage lies between the inputs and the outputs. The bench drives operands and the strobe on a falling edge and removes the strobe on the next falling edge. It compares valid_o, bypass_o, result_o and invalid_o at that same falling edge, half a period after the capturing rising edge. For the hold behaviour, the bench leaves one idle cycle and checks at the next falling edge that valid_o has dropped and that the other outputs are unchanged.

// File: rtl/fma_sc_pkg.sv
package fma_sc_pkg;
  parameter int unsigned EXP_W  = 8;
  parameter int unsigned FRAC_W = 23;

  typedef enum logic [2:0] {
    CLS_ZERO, CLS_FIN, CLS_INF, CLS_QNAN, CLS_SNAN
  } opnd_cls_e;

  typedef enum logic [1:0] {
    RND_NE = 2'b00, RND_DN = 2'b01, RND_UP = 2'b10, RND_TZ = 2'b11
  } rnd_e;

  typedef struct packed {
    opnd_cls_e cls;
    logic      sgn;
  } opnd_info_t;
endpackage

// File: rtl/fma_sc_classify.sv
module fma_sc_classify
  import fma_sc_pkg::*;
#(
  parameter int unsigned EW = EXP_W,
  parameter int unsigned FW = FRAC_W,
  localparam int unsigned W = 1 + EW + FW
) (
  input  logic [W-1:0] word_i,
  output opnd_info_t   info_o
);
  logic [EW-1:0] exp_f;
  logic [FW-1:0] frac_f;

  assign exp_f  = word_i[W-2 -: EW];
  assign frac_f = word_i[FW-1:0];

  always_comb begin
    info_o.sgn = word_i[W-1];
    if (exp_f == '0)
      info_o.cls = (frac_f == '0) ? CLS_ZERO : CLS_FIN;  // subnormals count as finite
    else if (exp_f != '1)
      info_o.cls = CLS_FIN;
    else if (frac_f == '0)
      info_o.cls = CLS_INF;
    else
      info_o.cls = frac_f[FW-1] ? CLS_QNAN : CLS_SNAN;
  end
endmodule

// File: rtl/fma_sc_resolve.sv
module fma_sc_resolve
  import fma_sc_pkg::*;
#(
  parameter int unsigned EW = EXP_W,
  parameter int unsigned FW = FRAC_W,
  localparam int unsigned W = 1 + EW + FW
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  input  opnd_info_t   xi_i,
  input  opnd_info_t   yi_i,
  input  opnd_info_t   zi_i,
  input  logic [1:0]   op_i,
  input  logic [1:0]   rnd_i,
  input  logic         cancel_i,
  output logic         bypass_o,
  output logic [W-1:0] result_o,
  output logic         invalid_o
);
  localparam logic [W-1:0] INDEF = {1'b1, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};
  localparam logic [W-1:0] QBIT  = {{(W-FW){1'b0}}, 1'b1, {(FW-1){1'b0}}};

  logic x_nan, y_nan, z_nan, any_snan;
  logic p_sgn, z_sgn, down;
  logic p_zero, p_inf, p_bad, z_zero, z_inf, z_fin;

  assign x_nan    = xi_i.cls inside {CLS_QNAN, CLS_SNAN};
  assign y_nan    = yi_i.cls inside {CLS_QNAN, CLS_SNAN};
  assign z_nan    = zi_i.cls inside {CLS_QNAN, CLS_SNAN};
  assign any_snan = (xi_i.cls == CLS_SNAN) || (yi_i.cls == CLS_SNAN) || (zi_i.cls == CLS_SNAN);

  assign p_sgn  = xi_i.sgn ^ yi_i.sgn ^ op_i[1];
  assign z_sgn  = zi_i.sgn ^ op_i[0];
  assign down   = (rnd_e'(rnd_i) == RND_DN);

  assign p_zero = (xi_i.cls == CLS_ZERO) || (yi_i.cls == CLS_ZERO);
  assign p_inf  = (xi_i.cls == CLS_INF)  || (yi_i.cls == CLS_INF);
  assign p_bad  = p_zero && p_inf;
  assign z_zero = (zi_i.cls == CLS_ZERO);
  assign z_inf  = (zi_i.cls == CLS_INF);
  assign z_fin  = (zi_i.cls == CLS_FIN);

  always_comb begin
    bypass_o  = 1'b1;
    invalid_o = 1'b0;
    result_o  = '0;
    if (x_nan || y_nan || z_nan) begin
      invalid_o = any_snan;
      if (x_nan)      result_o = x_i | QBIT;
      else if (y_nan) result_o = y_i | QBIT;
      else            result_o = z_i | QBIT;
    end else if (p_bad) begin
      invalid_o = 1'b1;
      result_o  = INDEF;
    end else if (p_inf) begin
      if (z_inf && (z_sgn != p_sgn)) begin
        invalid_o = 1'b1;
        result_o  = INDEF;
      end else begin
        result_o = {p_sgn, {EW{1'b1}}, {FW{1'b0}}};
      end
    end else if (z_inf) begin
      result_o = {z_sgn, {EW{1'b1}}, {FW{1'b0}}};
    end else if (p_zero && z_zero) begin
      result_o = {(p_sgn == z_sgn) ? p_sgn : down, {(W-1){1'b0}}};
    end else if (p_zero && z_fin) begin
      result_o = {z_sgn, z_i[W-2:0]};
    end else if (z_fin && cancel_i) begin
      result_o = {down, {(W-1){1'b0}}};
    end else begin
      bypass_o = 1'b0;  // product finite, addend finite or zero: datapath owns it
    end
  end
endmodule

// File: rtl/fma_special_resolver.sv
module fma_special_resolver
  import fma_sc_pkg::*;
#(
  parameter int unsigned EW = EXP_W,
  parameter int unsigned FW = FRAC_W,
  localparam int unsigned W = 1 + EW + FW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  input  logic [1:0]   op_i,
  input  logic [1:0]   rnd_i,
  input  logic         cancel_i,
  output logic         valid_o,
  output logic         bypass_o,
  output logic [W-1:0] result_o,
  output logic         invalid_o
);
  localparam int unsigned N_OPND = 3;

  logic [W-1:0] opnd   [N_OPND];
  opnd_info_t   info   [N_OPND];
  logic         byp_d, inv_d;
  logic [W-1:0] res_d;

  assign opnd[0] = x_i;
  assign opnd[1] = y_i;
  assign opnd[2] = z_i;

  for (genvar g = 0; g < N_OPND; g++) begin : g_cls
    fma_sc_classify #(.EW(EW), .FW(FW)) u_cls (
      .word_i (opnd[g]),
      .info_o (info[g])
    );
  end

  fma_sc_resolve #(.EW(EW), .FW(FW)) u_res (
    .x_i      (x_i),
    .y_i      (y_i),
    .z_i      (z_i),
    .xi_i     (info[0]),
    .yi_i     (info[1]),
    .zi_i     (info[2]),
    .op_i     (op_i),
    .rnd_i    (rnd_i),
    .cancel_i (cancel_i),
    .bypass_o (byp_d),
    .result_o (res_d),
    .invalid_o(inv_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      bypass_o  <= 1'b0;
      result_o  <= '0;
      invalid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        bypass_o  <= byp_d;
        result_o  <= res_d;
        invalid_o <= inv_d;
      end
    end
  end

  p_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(bypass_o) && $stable(invalid_o)));
  p_invalid_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && invalid_o) |-> (bypass_o && result_o[W-2 -: EW] == '1 && result_o[FW-1]));
  p_no_bypass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !bypass_o) |-> (result_o == '0 && !invalid_o));
  p_zeroinf_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && info[0].cls == CLS_ZERO && info[1].cls == CLS_INF && info[2].cls inside {CLS_ZERO, CLS_FIN, CLS_INF})
    |=> (invalid_o && result_o == {1'b1, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}}));
endmodule

// File: tb/fma_special_resolver_test.sv
`timescale 1ns/1ps
module fma_special_resolver_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] x_i = '0, y_i = '0, z_i = '0;
  logic [1:0]  op_i = '0, rnd_i = '0;
  logic        cancel_i = 1'b0;
  logic        valid_o, bypass_o, invalid_o;
  logic [31:0] result_o;
  int compared = 0, mismatched = 0;
  bit done = 0;

  localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
  localparam logic [31:0] ONE = 32'h3F80_0000, NONE = 32'hBF80_0000, TWO = 32'h4000_0000;
  localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000, INDEF = 32'hFFC0_0000;

  always #2.5 clk = ~clk;

  fma_special_resolver uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .x_i(x_i), .y_i(y_i), .z_i(z_i),
    .op_i(op_i), .rnd_i(rnd_i), .cancel_i(cancel_i), .valid_o(valid_o),
    .bypass_o(bypass_o), .result_o(result_o), .invalid_o(invalid_o)
  );

  task automatic chk(string tag, logic v, logic b, logic [31:0] r, logic inv);
    compared++;
    if (valid_o !== v || bypass_o !== b || result_o !== r || invalid_o !== inv) begin
      mismatched++;
      $display("FAIL %s: got v=%b b=%b r=%h i=%b exp v=%b b=%b r=%h i=%b",
               tag, valid_o, bypass_o, result_o, invalid_o, v, b, r, inv);
    end
  endtask

  task automatic run(string tag, logic [31:0] x, logic [31:0] y, logic [31:0] z,
                     logic [1:0] op, logic [1:0] rnd, logic c,
                     logic b, logic [31:0] r, logic inv);
    @(negedge clk);
    x_i = x; y_i = y; z_i = z; op_i = op; rnd_i = rnd; cancel_i = c; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    chk(tag, 1'b1, b, r, inv);
  endtask

  task automatic t_reset();
    chk("R11 reset", 1'b0, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic t_nan();
    run("R2 x qnan first", 32'h7FC0_0011, 32'h7FC0_0022, ONE, 2'b00, 2'b00, 0, 1, 32'h7FC0_0011, 0);
    run("R2 y before z", ONE, 32'hFFC0_0033, 32'h7F80_0005, 2'b00, 2'b00, 0, 1, 32'hFFC0_0033, 1);
    run("R3 snan quieted", ONE, TWO, 32'hFF81_2345, 2'b11, 2'b00, 0, 1, 32'hFFC1_2345, 1);
    run("R3 x snan", 32'h7F80_0005, PZ, PINF, 2'b00, 2'b00, 0, 1, 32'h7FC0_0005, 1);
  endtask

  task automatic t_inf();
    run("R5 zero*inf", PZ, PINF, ONE, 2'b00, 2'b00, 0, 1, INDEF, 1);
    run("R5 inf*zero", NINF, NZ, PINF, 2'b01, 2'b01, 0, 1, INDEF, 1);
    run("R4 inf + -inf", PINF, ONE, NINF, 2'b00, 2'b00, 0, 1, INDEF, 1);
    run("R4 inf - inf", PINF, ONE, PINF, 2'b01, 2'b00, 0, 1, INDEF, 1);
    run("R4 inf + inf", PINF, ONE, PINF, 2'b00, 2'b00, 0, 1, PINF, 0);
    run("R1 -(inf)+inf", PINF, ONE, PINF, 2'b10, 2'b00, 0, 1, INDEF, 1);
    run("R1 -(inf)-inf", PINF, ONE, PINF, 2'b11, 2'b00, 0, 1, NINF, 0);
    run("R1 x*y - -inf", ONE, ONE, NINF, 2'b01, 2'b00, 0, 1, PINF, 0);
    run("R1 -(neg prod inf)", NINF, ONE, TWO, 2'b10, 2'b10, 0, 1, PINF, 0);
  endtask

  task automatic t_zero();
    for (int m = 0; m < 4; m++) begin
      run("R6 +0 + +0", PZ, ONE, PZ, 2'b00, 2'(m), 0, 1, PZ, 0);
      run("R6 -0 + -0", NZ, ONE, NZ, 2'b00, 2'(m), 0, 1, NZ, 0);
      run("R6 -(+0)-(+0)", PZ, ONE, PZ, 2'b11, 2'(m), 0, 1, NZ, 0);
      run("R7 +0 + -0", PZ, ONE, NZ, 2'b00, 2'(m), 0, 1, (m == 1) ? NZ : PZ, 0);
      run("R7 +0 - +0", ONE, PZ, PZ, 2'b01, 2'(m), 0, 1, (m == 1) ? NZ : PZ, 0);
    end
  endtask

  task automatic t_cancel();
    for (int m = 0; m < 4; m++)
      run("R8 cancel", ONE, ONE, NONE, 2'b00, 2'(m), 1, 1, (m == 1) ? NZ : PZ, 0);
    run("R8 hint ignored on inf", ONE, ONE, PINF, 2'b00, 2'b01, 1, 1, PINF, 0);
    run("R8 hint ignored on zero addend", ONE, TWO, PZ, 2'b00, 2'b01, 1, 0, PZ, 0);
    run("R8 hint ignored on zero product", PZ, TWO, ONE, 2'b00, 2'b01, 1, 1, ONE, 0);
  endtask

  task automatic t_finite();
    run("R9 finite no hint", ONE, TWO, ONE, 2'b00, 2'b00, 0, 0, PZ, 0);
    run("R9 finite, zero addend", TWO, TWO, NZ, 2'b11, 2'b10, 0, 0, PZ, 0);
    run("R12 zero prod, z passes", PZ, TWO, 32'h4040_0000, 2'b01, 2'b00, 0, 1, 32'hC040_0000, 0);
    run("R12 subnormal addend", NZ, ONE, 32'h0000_0001, 2'b00, 2'b11, 0, 1, 32'h0000_0001, 0);
  endtask

  task automatic t_hold();
    run("R10 strobe", PINF, ONE, PINF, 2'b11, 2'b00, 0, 1, NINF, 0);
    @(negedge clk);
    x_i = PZ; y_i = PINF; z_i = ONE;  // would be invalid if strobed
    @(negedge clk);
    chk("R10 hold, no strobe", 1'b0, 1'b1, NINF, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_nan();
    t_inf();
    t_zero();
    t_cancel();
    t_finite();
    t_hold();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule